// File: doc/BRIEF.md
# RNG Bring-Up Sequencer

This block is the control state machine that takes a hardware random number generator from reset to service. On a start request it runs the deterministic logic self-test, retrying it up to a parameterised number of attempts. After a clean first-attempt pass it runs the bias-selection search. It then commits the preferred configuration to the generator, tagged either as configured or as error. It does not contain the self-test engine, the search engine or the commit transport. It pulses a start strobe to each engine, reads back each engine's done and pass result, and raises a commit request that carries the state tag.

The sequence is strict. A self-test that passes only after a retry is still treated as a fault. Every failure path ends in the same commit, tagged error: self-test exhaustion, a late pass, a search failure such as insufficient entropy, or a rejected configured commit. After the commit handshake completes the sequencer returns to idle. Start requests that arrive while it is busy are dropped. The number of self-test attempts stays readable on a debug port until the next start.

States: IDLE (waiting), TEST_KICK (self-test start strobe), TEST_WAIT (awaiting self-test result), SRCH_KICK (search start strobe), SRCH_WAIT (awaiting search result), COMMIT_GOOD (commit tagged configured), COMMIT_BAD (commit tagged error).

Transitions:
- IDLE→TEST_KICK on start.
- TEST_KICK→TEST_WAIT always.
- TEST_WAIT on done:
  - a fail below the limit goes to TEST_KICK;
  - a fail at the limit goes to COMMIT_BAD;
  - a first-attempt pass goes to SRCH_KICK;
  - a later pass goes to COMMIT_BAD.
- SRCH_KICK→SRCH_WAIT always.
- SRCH_WAIT on done: a pass goes to COMMIT_GOOD and a fail goes to COMMIT_BAD.
- COMMIT_GOOD on ack: ok goes to IDLE and not ok goes to COMMIT_BAD.
- COMMIT_BAD→IDLE on ack.

Top module: `rng_bringup_seq`

## Requirements
- R1: After reset, busy_o, selftest_start_o, search_start_o and commit_req_o are 0 and attempt_cnt_o is 0.
- R2: A start_i sampled while idle gives a one-cycle selftest_start_o pulse in the next cycle. busy_o is 1 from that cycle until the sequencer is idle again.
- R3: attempt_cnt_o is cleared when a start is accepted. It increments in the cycle after each selftest_start_o pulse, and it keeps its final value after the return to idle until the next accepted start.
- R4: A self-test result with selftest_pass_i=0, taken while fewer than MAX_TRIES attempts have been made, gives a new selftest_start_o pulse in the next cycle.
- R5: A self-test failure on attempt MAX_TRIES gives, in the next cycle, commit_req_o=1 with commit_tag_o=1 (error), and no search_start_o is ever issued.
- R6: A self-test pass on the first attempt gives a one-cycle search_start_o pulse in the next cycle.
- R7: A self-test pass on any later attempt gives, in the next cycle, commit_req_o=1 with commit_tag_o=1 (error), and no search is started.
- R8: In the cycle after search_done_i, commit_req_o is 1 with commit_tag_o=0 (configured) if search_pass_i was 1, and with commit_tag_o=1 (error) otherwise.
- R9: commit_req_o stays 1 with a stable commit_tag_o until a cycle in which commit_ack_i is 1. A transfer happens in a cycle with both commit_req_o and commit_ack_i at 1.
- R10: A configured commit acknowledged with commit_ok_i=0 is reissued as an error commit (commit_tag_o=1) in the next cycle. One acknowledged with commit_ok_i=1 returns the sequencer to idle in the next cycle.
- R11: An error commit that is acknowledged returns the sequencer to idle in the next cycle, whatever the value of commit_ok_i.
- R12: start_i while busy_o=1 is ignored: it causes no extra selftest_start_o pulse and does not change attempt_cnt_o.
- R13: At most one of selftest_start_o, search_start_o and commit_req_o is 1 in any cycle, and each start strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the bring-up sequence |
| busy_o | output | 1 | Sequence in progress |
| selftest_start_o | output | 1 | One-cycle start strobe to the self-test engine |
| selftest_done_i | input | 1 | Self-test result valid |
| selftest_pass_i | input | 1 | Self-test passed (valid with done) |
| search_start_o | output | 1 | One-cycle start strobe to the bias-search engine |
| search_done_i | input | 1 | Search result valid |
| search_pass_i | input | 1 | Search found adequate entropy (valid with done) |
| commit_req_o | output | 1 | Configuration commit request |
| commit_tag_o | output | 1 | State tag of the commit: 0 configured, 1 error |
| commit_ack_i | input | 1 | Commit accepted by the transport |
| commit_ok_i | input | 1 | Commit succeeded (valid with ack) |
| attempt_cnt_o | output | $clog2(MAX_TRIES+1) | Self-test attempts made in the current or last run |

## Verification
Every result of this block appears exactly one cycle after the edge that samples its cause:
- the self-test strobe after an accepted start;
- a retry strobe, search strobe or commit request after an engine's done;
- the reissued or released commit after an ack;
- the counter step after each self-test strobe.

The bench drives each stimulus at a falling edge, steps to the next falling edge and checks there, so each check lands in the cycle the requirement names. During the random wait periods between stimulus and response, it also checks every cycle that nothing else moves and that stray start requests are dropped.

// File: rtl/rng_bringup_pkg.sv
package rng_bringup_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE        = 3'd0,
        SQ_TEST_KICK   = 3'd1,
        SQ_TEST_WAIT   = 3'd2,
        SQ_SRCH_KICK   = 3'd3,
        SQ_SRCH_WAIT   = 3'd4,
        SQ_COMMIT_GOOD = 3'd5,
        SQ_COMMIT_BAD  = 3'd6
    } seq_state_e;

    typedef enum logic {
        TAG_CONFIGURED = 1'b0,
        TAG_ERROR      = 1'b1
    } commit_tag_e;

endpackage

// File: rtl/rng_try_counter.sv
module rng_try_counter #(
    parameter int MAX_TRIES = 3,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             bump_i,
    output logic [CNT_W-1:0] count_o,
    output logic             first_o,
    output logic             limit_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_TRIES);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (bump_i && (count_q != LIMIT)) begin
            count_q <= count_q + ONE;
        end
    end

    assign count_o = count_q;
    assign first_o = (count_q == ONE);
    assign limit_o = (count_q >= LIMIT);

endmodule

// File: rtl/rng_seq_fsm.sv
module rng_seq_fsm
    import rng_bringup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       test_done_i,
    input  logic       test_pass_i,
    input  logic       first_try_i,
    input  logic       last_try_i,
    input  logic       srch_done_i,
    input  logic       srch_pass_i,
    input  logic       commit_ack_i,
    input  logic       commit_ok_i,
    output seq_state_e state_o,
    output logic       cnt_clear_o,
    output logic       cnt_bump_o,
    output logic       test_kick_o,
    output logic       srch_kick_o,
    output logic       commit_req_o,
    output logic       commit_tag_o,
    output logic       busy_o
);
    seq_state_e state_q;
    seq_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and counter control
    always_comb begin
        state_d     = state_q;
        cnt_clear_o = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (start_i) begin
                    state_d     = SQ_TEST_KICK;
                    cnt_clear_o = 1'b1;
                end
            end
            SQ_TEST_KICK: begin
                state_d = SQ_TEST_WAIT;
            end
            SQ_TEST_WAIT: begin
                if (test_done_i) begin
                    if (test_pass_i) begin
                        state_d = first_try_i ? SQ_SRCH_KICK : SQ_COMMIT_BAD;
                    end else begin
                        state_d = last_try_i ? SQ_COMMIT_BAD : SQ_TEST_KICK;
                    end
                end
            end
            SQ_SRCH_KICK: begin
                state_d = SQ_SRCH_WAIT;
            end
            SQ_SRCH_WAIT: begin
                if (srch_done_i) begin
                    state_d = srch_pass_i ? SQ_COMMIT_GOOD : SQ_COMMIT_BAD;
                end
            end
            SQ_COMMIT_GOOD: begin
                if (commit_ack_i) begin
                    state_d = commit_ok_i ? SQ_IDLE : SQ_COMMIT_BAD;
                end
            end
            SQ_COMMIT_BAD: begin
                if (commit_ack_i) begin
                    state_d = SQ_IDLE;
                end
            end
            default: begin
                state_d = SQ_IDLE;
            end
        endcase
    end

    // Moore outputs
    always_comb begin
        test_kick_o  = 1'b0;
        srch_kick_o  = 1'b0;
        commit_req_o = 1'b0;
        commit_tag_o = TAG_CONFIGURED;
        busy_o       = 1'b1;
        cnt_bump_o   = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                busy_o = 1'b0;
            end
            SQ_TEST_KICK: begin
                test_kick_o = 1'b1;
                cnt_bump_o  = 1'b1;
            end
            SQ_TEST_WAIT: begin
            end
            SQ_SRCH_KICK: begin
                srch_kick_o = 1'b1;
            end
            SQ_SRCH_WAIT: begin
            end
            SQ_COMMIT_GOOD: begin
                commit_req_o = 1'b1;
                commit_tag_o = TAG_CONFIGURED;
            end
            SQ_COMMIT_BAD: begin
                commit_req_o = 1'b1;
                commit_tag_o = TAG_ERROR;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/rng_bringup_seq.sv
module rng_bringup_seq
    import rng_bringup_pkg::*;
#(
    parameter  int MAX_TRIES = 3,
    localparam int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             selftest_start_o,
    input  logic             selftest_done_i,
    input  logic             selftest_pass_i,
    output logic             search_start_o,
    input  logic             search_done_i,
    input  logic             search_pass_i,
    output logic             commit_req_o,
    output logic             commit_tag_o,
    input  logic             commit_ack_i,
    input  logic             commit_ok_i,
    output logic [CNT_W-1:0] attempt_cnt_o
);
    seq_state_e state_w;
    logic       cnt_clear;
    logic       cnt_bump;
    logic       first_try;
    logic       last_try;

    rng_try_counter #(
        .MAX_TRIES (MAX_TRIES),
        .CNT_W     (CNT_W)
    ) try_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .bump_i  (cnt_bump),
        .count_o (attempt_cnt_o),
        .first_o (first_try),
        .limit_o (last_try)
    );

    rng_seq_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .test_done_i  (selftest_done_i),
        .test_pass_i  (selftest_pass_i),
        .first_try_i  (first_try),
        .last_try_i   (last_try),
        .srch_done_i  (search_done_i),
        .srch_pass_i  (search_pass_i),
        .commit_ack_i (commit_ack_i),
        .commit_ok_i  (commit_ok_i),
        .state_o      (state_w),
        .cnt_clear_o  (cnt_clear),
        .cnt_bump_o   (cnt_bump),
        .test_kick_o  (selftest_start_o),
        .srch_kick_o  (search_start_o),
        .commit_req_o (commit_req_o),
        .commit_tag_o (commit_tag_o),
        .busy_o       (busy_o)
    );

endmodule

// File: rtl/rng_bringup_seq_chk.sv
module rng_bringup_seq_chk
    import rng_bringup_pkg::*;
#(
    parameter int MAX_TRIES = 3,
    parameter int CNT_W     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             selftest_start_o,
    input logic             selftest_done_i,
    input logic             selftest_pass_i,
    input logic             search_start_o,
    input logic             search_done_i,
    input logic             search_pass_i,
    input logic             commit_req_o,
    input logic             commit_tag_o,
    input logic             commit_ack_i,
    input logic             commit_ok_i,
    input logic [CNT_W-1:0] attempt_cnt_o,
    input seq_state_e       state_w
);
    logic test_wait_done;
    assign test_wait_done = (state_w == SQ_TEST_WAIT) && selftest_done_i;

    p_kick_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (selftest_start_o && busy_o));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_start_o |=> (attempt_cnt_o == $past(attempt_cnt_o) + 1'b1));

    p_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_wait_done && !selftest_pass_i && (int'(attempt_cnt_o) < MAX_TRIES))
        |=> selftest_start_o);

    p_exhaust_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_wait_done && !selftest_pass_i && (int'(attempt_cnt_o) >= MAX_TRIES))
        |=> (commit_req_o && commit_tag_o && !search_start_o));

    p_first_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_wait_done && selftest_pass_i && (int'(attempt_cnt_o) == 1))
        |=> search_start_o);

    p_late_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_wait_done && selftest_pass_i && (int'(attempt_cnt_o) > 1))
        |=> (commit_req_o && commit_tag_o));

    p_search_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_w == SQ_SRCH_WAIT) && search_done_i)
        |=> (commit_req_o && (commit_tag_o == !$past(search_pass_i))));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req_o && !commit_ack_i) |=> (commit_req_o && $stable(commit_tag_o)));

    p_reissue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req_o && !commit_tag_o && commit_ack_i && !commit_ok_i)
        |=> (commit_req_o && commit_tag_o));

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req_o && commit_tag_o && commit_ack_i) |=> (!busy_o && !commit_req_o));

    p_one_action_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({selftest_start_o, search_start_o, commit_req_o}));

    p_strobe_width_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (selftest_start_o || search_start_o) |=> (!selftest_start_o && !search_start_o));

endmodule

bind rng_bringup_seq rng_bringup_seq_chk #(
    .MAX_TRIES (MAX_TRIES),
    .CNT_W     (CNT_W)
) chk_i (.*);

// File: tb/rng_bringup_seq_tb.sv
`timescale 1ns/1ps
module rng_bringup_seq_tb_top;
    localparam int MAX_TRIES = 3;
    localparam int CNT_W     = $clog2(MAX_TRIES + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic st_done = 1'b0, st_pass = 1'b0;
    logic sr_done = 1'b0, sr_pass = 1'b0;
    logic ack = 1'b0, ok = 1'b0;
    logic busy_o, selftest_start_o, search_start_o, commit_req_o, commit_tag_o;
    logic [CNT_W-1:0] attempt_cnt_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rng_bringup_seq #(.MAX_TRIES(MAX_TRIES)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .busy_o           (busy_o),
        .selftest_start_o (selftest_start_o),
        .selftest_done_i  (st_done),
        .selftest_pass_i  (st_pass),
        .search_start_o   (search_start_o),
        .search_done_i    (sr_done),
        .search_pass_i    (sr_pass),
        .commit_req_o     (commit_req_o),
        .commit_tag_o     (commit_tag_o),
        .commit_ack_i     (ack),
        .commit_ok_i      (ok),
        .attempt_cnt_o    (attempt_cnt_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit good, input string rq, input longint act, input longint exp);
        checks++;
        if (!good) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int exp_tries(input int nfail);
        return (nfail + 1 > MAX_TRIES) ? MAX_TRIES : nfail + 1;
    endfunction

    function automatic bit exp_search(input int nfail);
        return nfail == 0;
    endfunction

    // wait with stray starts while busy; nothing may move (R12, R9 when committing)
    task automatic idle_wait(input int n, input int cnt, input bit in_commit, input bit tag);
        for (int k = 0; k < n; k++) begin
            start_i = 1'($urandom_range(0, 1));
            tick();
            chk(selftest_start_o == 0, "R12 no extra self-test start", selftest_start_o, 0);
            chk(int'(attempt_cnt_o) == cnt, "R12 counter unchanged", attempt_cnt_o, cnt);
            if (in_commit) begin
                chk(commit_req_o == 1, "R9 request held", commit_req_o, 1);
                chk(commit_tag_o == tag, "R9 tag stable", commit_tag_o, tag);
            end
        end
        start_i = 1'b0;
    endtask

    task automatic commit_phase(input bit tag, input bit okv, input int cnt);
        chk(commit_req_o == 1, "R9 request raised", commit_req_o, 1);
        chk(commit_tag_o == tag, "R9 request tag", commit_tag_o, tag);
        idle_wait($urandom_range(0, 4), cnt, 1'b1, tag);
        ack = 1'b1; ok = okv;
        tick();
        ack = 1'b0; ok = 1'b0;
    endtask

    task automatic run_case(input int nfail, input bit sok, input bit cok);
        int a;
        int ntries = exp_tries(nfail);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        chk(busy_o == 1, "R2 busy after start", busy_o, 1);
        chk(attempt_cnt_o == 0, "R3 counter cleared on start", attempt_cnt_o, 0);
        for (a = 1; a <= MAX_TRIES; a++) begin
            chk(selftest_start_o == 1, (a == 1) ? "R2 self-test strobe" : "R4 retry strobe",
                selftest_start_o, 1);
            tick();
            chk(selftest_start_o == 0, "R13 strobe one cycle", selftest_start_o, 0);
            chk(int'(attempt_cnt_o) == a, "R3 counter step", attempt_cnt_o, a);
            idle_wait($urandom_range(0, 4), a, 1'b0, 1'b0);
            st_done = 1'b1; st_pass = (a > nfail);
            tick();
            st_done = 1'b0; st_pass = 1'b0;
            if (a > nfail || a == MAX_TRIES) break;
        end
        chk(int'(attempt_cnt_o) == ntries, "R3 attempts made", attempt_cnt_o, ntries);
        if (exp_search(nfail)) begin
            chk(search_start_o == 1, "R6 search strobe", search_start_o, 1);
            tick();
            chk(search_start_o == 0 && commit_req_o == 0, "R13 search strobe one cycle",
                search_start_o, 0);
            idle_wait($urandom_range(0, 4), ntries, 1'b0, 1'b0);
            sr_done = 1'b1; sr_pass = sok;
            tick();
            sr_done = 1'b0; sr_pass = 1'b0;
            chk(commit_tag_o == !sok, "R8 commit tag from search", commit_tag_o, !sok);
            if (sok) begin
                commit_phase(1'b0, cok, ntries);
                if (cok) begin
                    chk(busy_o == 0 && commit_req_o == 0, "R10 idle after good commit", busy_o, 0);
                end else begin
                    chk(commit_req_o == 1 && commit_tag_o == 1, "R10 reissued as error",
                        commit_tag_o, 1);
                    commit_phase(1'b1, 1'($urandom_range(0, 1)), ntries);
                    chk(busy_o == 0 && commit_req_o == 0, "R11 idle after error commit", busy_o, 0);
                end
            end else begin
                commit_phase(1'b1, cok, ntries);
                chk(busy_o == 0 && commit_req_o == 0, "R11 idle after error commit", busy_o, 0);
            end
        end else begin
            chk(search_start_o == 0, (nfail >= MAX_TRIES) ? "R5 no search" : "R7 no search",
                search_start_o, 0);
            chk(commit_req_o == 1 && commit_tag_o == 1,
                (nfail >= MAX_TRIES) ? "R5 error commit" : "R7 error commit", commit_tag_o, 1);
            commit_phase(1'b1, cok, ntries);
            chk(busy_o == 0 && commit_req_o == 0, "R11 idle after error commit", busy_o, 0);
        end
        tick();
        chk(int'(attempt_cnt_o) == ntries, "R3 counter held in idle", attempt_cnt_o, ntries);
        chk(busy_o == 0 && selftest_start_o == 0, "R2 stays idle", busy_o, 0);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) tick();
        chk(busy_o == 0 && commit_req_o == 0, "R1 reset idle", busy_o, 0);
        chk(selftest_start_o == 0 && search_start_o == 0, "R1 reset strobes", selftest_start_o, 0);
        chk(attempt_cnt_o == 0, "R1 reset counter", attempt_cnt_o, 0);
        rst_n = 1'b1;
        tick();
        chk(busy_o == 0, "R1 idle after release", busy_o, 0);
        // directed corners
        run_case(0, 1'b1, 1'b1);
        run_case(0, 1'b0, 1'b1);
        run_case(0, 1'b1, 1'b0);
        run_case(1, 1'b1, 1'b1);
        run_case(MAX_TRIES - 1, 1'b1, 1'b0);
        run_case(MAX_TRIES, 1'b1, 1'b1);
        // random mix
        for (int n = 0; n < 40; n++) begin
            run_case($urandom_range(0, MAX_TRIES), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)));
            repeat ($urandom_range(0, 3)) tick();
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule